// File: doc/BRIEF.md
# Early-Out Sequential Shift-Add Multiplier

This block multiplies two integers one multiplier bit per clock. Signed (two's-complement) and unsigned operands are accepted at a quarter, half or full data width (8, 16 or 32 bits by default). The block returns the double-width product as a high word and a low word. A caller presents the operands with a one-cycle start strobe and waits for a one-cycle done pulse. Once the pulse arrives, the product words stay stable until the next result.

The datapath keeps a multiplicand register, an upper accumulator one bit wider than the data path, a combined multiplier/low-product register and a down-counter. The bit in the lowest position of the multiplier/low-product register decides whether the multiplicand is added. The accumulator and that register are then shifted right together. The loop stops as soon as the multiplier bits not yet used carry no more information: all zero when unsigned, all equal when signed. The negative-multiplier correction is then applied at the exit scale. A single multi-bit right shift by the remaining count then puts the product in place. All widths share this sequence. A narrow product is read from the low bits of the accumulator and the upper bits of the low-product register.

A cycle-count output reports the latency of the last operation, so a checker can follow the early exit.

Top module: `seqmul_eo`

## Requirements
- R1: When `start` is high and the block is idle, it captures `is_signed`, `op_size` and both operands. The size code is 2'b00 = DATA_W/4 bits, 2'b01 = DATA_W/2 bits, and 2'b10 or 2'b11 = DATA_W bits. Operand bits above the selected width have no effect on the result.
- R2: When `is_signed` is 0, {`prod_hi`, `prod_lo`} holds the exact unsigned product of the width-bit operands. Each word carries its half in its low width bits, and the word bits above the width are zero.
- R3: When `is_signed` is 1, the product is the exact two's-complement product, split into two width-bit halves in the same way, with the word bits above the width zero.
- R4: The loop consumes one multiplier bit per cycle. After iteration i, with i at least 3 and less than the width, the loop exits when multiplier bits [width-1:i] are all zero (either mode) or all one (signed mode only). Otherwise it runs for exactly width iterations.
- R5: With n iterations, `done` rises in cycle n+6 counted after the start cycle, and `cycle_count` reads n+6. The latency is therefore 9 to width+6 cycles.
- R6: `done` is high for exactly one cycle. The product words and `cycle_count` change in that same cycle and hold until the next `done`.
- R7: A `start` while an operation is in progress is ignored. It neither disturbs the running product nor queues a second operation.
- R8: A low `rst_n` on a clock edge returns the block to idle, with `done`, `prod_hi`, `prod_lo` and `cycle_count` at zero. An operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_size | input | 2 | Operand width code (00 quarter, 01 half, 1x full) |
| multiplicand | input | DATA_W | Multiplicand, low width bits used |
| multiplier | input | DATA_W | Multiplier, low width bits used |
| done | output | 1 | One-cycle result-valid pulse |
| prod_hi | output | DATA_W | Upper product half, zero above the width |
| prod_lo | output | DATA_W | Lower product half, zero above the width |
| cycle_count | output | CYC_W | Latency of the last operation in cycles |

## Verification
Every cycle, the assertions check the following. `done` never lasts two cycles. A start seen while busy never restarts the sequence. The loop never runs past the operand width. The remaining count stays frozen through the correction and alignment steps. A reported latency lies between 9 and width+6. At output time the accumulator holds a high half that fits the width (zero-extended or sign-extended). Whether the product values are exact, and whether the early exit fires on the right iteration for a given multiplier, can only be shown by the bench's scenarios. These cover the vector table, the ignored-operand-bits cases, a start injected during a busy full-width operation, and a reset in mid-operation.

// File: rtl/seqmul_pkg.sv
// Shared types for the early-out sequential multiplier.
// Assumes: every module of the block imports this package.
package seqmul_pkg;

    // Sequencer phases, in the order they occur for one operation.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LDA   = 3'd1,   // load multiplicand, counter
        ST_LDB   = 3'd2,   // load multiplier, clear accumulator
        ST_LOOP  = 3'd3,   // one add-and-shift per cycle
        ST_FIX   = 3'd4,   // negative-multiplier correction
        ST_ALIGN = 3'd5,   // multi-bit right shift by remaining count
        ST_OUT   = 3'd6    // slice product into output words
    } seq_state_t;

    // Fixed number of non-loop cycles in an operation's latency.
    localparam int SEQ_OVERHEAD = 6;

endpackage

// File: rtl/seqmul_ctrl.sv
// Sequencer for the early-out multiplier: captures the mode, walks the
// phases, runs the down-counter and the iteration count, decides the
// early exit and measures the latency.
// Assumes: tail_uniform is valid in ST_LOOP for the current counter value.
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MIN_ITER = 3,
    parameter int CNT_W    = 5,
    parameter int CYC_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sgn_in,
    input  logic [1:0]       size_in,
    input  logic             tail_uniform,
    output seq_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             sgn,
    output logic [CNT_W:0]   width,
    output logic             done,
    output logic [CYC_W-1:0] cycles
);

    logic [1:0]       size_q;
    logic [CNT_W:0]   it_q;
    logic [CNT_W:0]   it_next;
    logic [CYC_W-1:0] cyc_q;
    logic             loop_end;

    // Operand width in bits from the captured size code.
    always_comb begin : width_decode
        case (size_q)
            2'b00:   width = (CNT_W+1)'(DATA_W / 4);
            2'b01:   width = (CNT_W+1)'(DATA_W / 2);
            default: width = (CNT_W+1)'(DATA_W);
        endcase
    end

    assign it_next  = it_q + (CNT_W+1)'(1);
    assign loop_end = (cnt == '0) ||
                      ((it_next >= (CNT_W+1)'(MIN_ITER)) && tail_uniform);

    // Phase register, counters and result strobe.
    always_ff @(posedge clk) begin : seq_regs
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            it_q   <= '0;
            sgn    <= 1'b0;
            size_q <= 2'b00;
            cyc_q  <= '0;
            cycles <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE) cyc_q <= cyc_q + CYC_W'(1);
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_LDA;
                    sgn    <= sgn_in;
                    size_q <= size_in;
                    cyc_q  <= CYC_W'(1);
                end
                ST_LDA: begin
                    cnt   <= CNT_W'(width - (CNT_W+1)'(1));
                    it_q  <= '0;
                    state <= ST_LDB;
                end
                ST_LDB:  state <= ST_LOOP;
                ST_LOOP: begin
                    it_q <= it_next;
                    if (loop_end) state <= ST_FIX;
                    else          cnt   <= cnt - CNT_W'(1);
                end
                ST_FIX:   state <= ST_ALIGN;
                ST_ALIGN: state <= ST_OUT;
                ST_OUT: begin
                    state  <= ST_IDLE;
                    done   <= 1'b1;
                    cycles <= cyc_q + CYC_W'(1);
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R6: the result strobe lasts a single cycle.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a start seen while busy never restarts the sequence.
    assert_busy_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> (state != ST_LDA));

    // R4: the loop never runs more iterations than the operand width.
    assert_loop_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP) |-> (it_q < width));

    // R4: the remaining count is frozen through correction and alignment.
    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX || state == ST_ALIGN) |=> $stable(cnt));

    // R5: a reported latency lies between the early-out floor and width+6.
    assert_latency_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CYC_W'(MIN_ITER + SEQ_OVERHEAD) &&
                  cycles <= CYC_W'(width) + CYC_W'(SEQ_OVERHEAD)));

endmodule

// File: rtl/seqmul_dpath.sv
// Datapath of the early-out multiplier: operand capture, the add-and-shift
// step, the detector for remaining multiplier bits, the sign correction,
// the alignment shifter and the output slicing.
// Assumes: state/cnt/sgn/width come from seqmul_ctrl; capture is high only
// in the cycle a start is accepted.
module seqmul_dpath
    import seqmul_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sgn,
    input  logic [CNT_W:0]    width,
    input  logic              capture,
    input  logic [DATA_W-1:0] mcand_in,
    input  logic [DATA_W-1:0] mplier_in,
    output logic              tail_uniform,
    output logic [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0] prod_lo
);

    localparam int ACC_W = DATA_W + 1;
    localparam int CAT_W = ACC_W + DATA_W + 1;

    logic [DATA_W-1:0] opa_q, opb_q;
    logic [ACC_W-1:0]  mcand_q, acc_q;
    logic [DATA_W-1:0] lo_q;
    logic              neg_q;
    logic [CNT_W-1:0]  msb_idx;
    logic [ACC_W-1:0]  addend, sum, acc_step;
    logic [DATA_W-1:0] lo_step, tail_mask, tail_bits;
    logic [CAT_W-1:0]  cat;
    logic [ACC_W+DATA_W-1:0] aligned;
    logic [DATA_W-1:0] width_mask;
    logic [ACC_W-1:0]  hi_top;

    assign msb_idx = CNT_W'(width - (CNT_W+1)'(1));

    // Extends the low width bits of v to the accumulator width.
    function automatic logic [ACC_W-1:0] widen(input logic [DATA_W-1:0] v,
                                               input logic [CNT_W-1:0] top_idx,
                                               input logic s);
        logic [ACC_W-1:0] r;
        logic             fill;
        fill = s & v[top_idx];
        for (int k = 0; k < DATA_W; k++)
            r[k] = (k <= int'(top_idx)) ? v[k] : fill;
        r[ACC_W-1] = fill;
        return r;
    endfunction

    // One iteration: conditional add, then right shift of {acc, lo}.
    always_comb begin : step_calc
        addend   = lo_q[0] ? mcand_q : '0;
        sum      = acc_q + addend;
        acc_step = {sgn & sum[ACC_W-1], sum[ACC_W-1:1]};
        lo_step  = {sum[0], lo_q[DATA_W-1:1]};
    end

    // Mask selecting the multiplier bits still unconsumed after this step.
    for (genvar k = 0; k < DATA_W; k++) begin : g_tail_mask
        assign tail_mask[k] = (CNT_W'(k) < cnt);
    end
    assign tail_bits    = lo_step & tail_mask;
    assign tail_uniform = (tail_bits == '0) || (sgn && tail_bits == tail_mask);

    // Alignment shifter: one right shift by the remaining count.
    assign cat     = {sgn & acc_q[ACC_W-1], acc_q, lo_q};
    assign aligned = (ACC_W+DATA_W)'($signed(cat) >>> cnt);

    assign width_mask = {DATA_W{1'b1}} >> ((CNT_W+1)'(DATA_W) - width);
    assign hi_top     = ACC_W'($signed(acc_q) >>> msb_idx);

    // Operand capture at start acceptance.
    always_ff @(posedge clk) begin : op_capture
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (capture) begin
            opa_q <= mcand_in;
            opb_q <= mplier_in;
        end
    end

    // Working registers, advanced according to the sequencer phase.
    always_ff @(posedge clk) begin : work_regs
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            lo_q    <= '0;
            neg_q   <= 1'b0;
            prod_hi <= '0;
            prod_lo <= '0;
        end else begin
            case (state)
                ST_LDA: mcand_q <= widen(opa_q, msb_idx, sgn);
                ST_LDB: begin
                    acc_q <= '0;
                    lo_q  <= DATA_W'(widen(opb_q, msb_idx, 1'b0));
                    neg_q <= sgn & opb_q[msb_idx];
                end
                ST_LOOP: begin
                    acc_q <= acc_step;
                    lo_q  <= lo_step;
                end
                ST_FIX: if (neg_q) acc_q <= acc_q - mcand_q;
                ST_ALIGN: begin
                    acc_q <= aligned[ACC_W+DATA_W-1:DATA_W];
                    lo_q  <= aligned[DATA_W-1:0];
                end
                ST_OUT: begin
                    prod_hi <= acc_q[DATA_W-1:0] & width_mask;
                    prod_lo <= lo_q >> ((CNT_W+1)'(DATA_W) - width);
                end
                default: ;
            endcase
        end
    end

    // R2: an unsigned high half fits in the operand width at output time.
    assert_uhigh_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && !sgn) |-> ((acc_q >> width) == '0));

    // R3: a signed high half is sign-extended above the operand width.
    assert_shigh_extended_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && sgn) |-> (hi_top == '0 || hi_top == '1));

    // R3: the negative-multiplier correction is armed only in signed mode.
    assert_fix_signed_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX && !sgn) |-> !neg_q);

endmodule

// File: rtl/seqmul_eo.sv
// Early-out sequential shift-add multiplier, top level.
// One multiplier bit per cycle, early loop exit on uniform remaining bits,
// single-step realignment and signed correction.
// Assumes: DATA_W divisible by 4; MIN_ITER below DATA_W/4.
module seqmul_eo
    import seqmul_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MIN_ITER = 3,
    parameter int CYC_W    = $clog2(DATA_W + 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_signed,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] multiplicand,
    input  logic [DATA_W-1:0] multiplier,
    output logic              done,
    output logic [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0] prod_lo,
    output logic [CYC_W-1:0]  cycle_count
);

    localparam int CNT_W = $clog2(DATA_W);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             sgn;
    logic [CNT_W:0]   width;
    logic             tail_uniform;
    logic             capture;

    assign capture = start && (state == ST_IDLE);

    seqmul_ctrl #(
        .DATA_W(DATA_W), .MIN_ITER(MIN_ITER), .CNT_W(CNT_W), .CYC_W(CYC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_in(is_signed),
        .size_in(op_size), .tail_uniform(tail_uniform), .state(state),
        .cnt(cnt), .sgn(sgn), .width(width), .done(done), .cycles(cycle_count)
    );

    seqmul_dpath #(
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_dpath (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .sgn(sgn),
        .width(width), .capture(capture), .mcand_in(multiplicand),
        .mplier_in(multiplier), .tail_uniform(tail_uniform),
        .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

endmodule

// File: tb/seqmul_eo_test.sv
`timescale 1ns/1ps
module seqmul_eo_test;

    localparam int DW = 32;
    localparam int NV = 16;
    localparam int MINI = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [1:0]  op_size = 2'b00;
    logic [31:0] mcand = '0, mplier = '0;
    logic        done;
    logic [31:0] prod_hi, prod_lo;
    logic [5:0]  cycle_count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    seqmul_eo #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .op_size(op_size), .multiplicand(mcand), .multiplier(mplier),
        .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .cycle_count(cycle_count)
    );

    // Stimulus table: mode = {signed, size code}.
    localparam logic [2:0] VMODE [NV] = '{
        3'b000, 3'b000, 3'b100, 3'b100, 3'b001, 3'b101, 3'b101, 3'b010,
        3'b110, 3'b110, 3'b010, 3'b110, 3'b010, 3'b100, 3'b011, 3'b110};
    localparam logic [31:0] VA [NV] = '{
        32'h000000FF, 32'h00000007, 32'h00000080, 32'h00000005,
        32'h0000FFFF, 32'h00008000, 32'h00001234, 32'hFFFFFFFF,
        32'h80000000, 32'h7FFFFFFF, 32'h12345678, 32'hDEADBEEF,
        32'h00000000, 32'hABCDEF81, 32'h0000FFFF, 32'h00000007};
    localparam logic [31:0] VB [NV] = '{
        32'h000000FF, 32'h00000003, 32'h00000080, 32'h000000FF,
        32'h0000FFFF, 32'h00007FFF, 32'h0000FFF0, 32'hFFFFFFFF,
        32'h80000000, 32'h80000000, 32'h00000010, 32'hFFFFFFFE,
        32'h00000000, 32'h1234567F, 32'h00010001, 32'hC0000000};

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    endfunction

    function automatic logic [63:0] wmask(input int w);
        return (64'h1 << w) - 64'h1;
    endfunction

    // Reference: returns {hi word, lo word}, each width bits, zero above.
    function automatic logic [63:0] ref_prod(input logic s, input logic [1:0] sz,
                                             input logic [31:0] a, input logic [31:0] b);
        int w = bits_of(sz);
        logic [63:0] m = wmask(w);
        logic [63:0] ae = {32'h0, a} & m;
        logic [63:0] be = {32'h0, b} & m;
        logic [63:0] p;
        if (s && ae[w-1]) ae = ae | ~m;
        if (s && be[w-1]) be = be | ~m;
        p = ae * be;
        return {32'(((p >> w) & m)), 32'(p & m)};
    endfunction

    // Reference iteration count from the early-exit rule of R4.
    function automatic int ref_iters(input logic s, input logic [1:0] sz,
                                     input logic [31:0] b);
        int w = bits_of(sz);
        logic [63:0] m = wmask(w);
        for (int i = MINI; i < w; i++) begin
            logic [63:0] rem = (({32'h0, b} & m) >> i);
            if (rem == 64'h0 || (s && rem == (m >> i))) return i;
        end
        return w;
    endfunction

    // Issues one operation and checks product, latency and hold behaviour.
    task automatic run_op(input logic s, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [63:0] exp = ref_prod(s, sz, a, b);
        int n = ref_iters(s, sz, b);
        int k;
        logic [31:0] hi_c, lo_c;
        string preq = s ? "R3" : "R2";
        @(negedge clk);
        start = 1'b1; is_signed = s; op_size = sz; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check({preq, " ", tag}, "prod_hi", {32'h0, prod_hi}, {32'h0, exp[63:32]});
        check({preq, " ", tag}, "prod_lo", {32'h0, prod_lo}, {32'h0, exp[31:0]});
        check({"R4 R5 ", tag}, "done cycle", 64'(k), 64'(n + 6));
        check({"R5 ", tag}, "cycle_count", {58'h0, cycle_count}, 64'(n + 6));
        hi_c = prod_hi; lo_c = prod_lo;
        @(negedge clk);
        check({"R6 ", tag}, "done after pulse", {63'h0, done}, 64'h0);
        repeat (2) @(negedge clk);
        check({"R6 ", tag}, "held product", {prod_hi, prod_lo}, {hi_c, lo_c});
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main_seq
        int dones;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state.
        check("R8 reset", "done", {63'h0, done}, 64'h0);
        check("R8 reset", "product", {prod_hi, prod_lo}, 64'h0);
        check("R8 reset", "cycle_count", {58'h0, cycle_count}, 64'h0);

        // Table walk: R1-related vectors are 13 (ignored upper bits, R1)
        // and 14 (size code 2'b11 selects full width, R1).
        for (int v = 0; v < NV; v++) begin
            string t = (v == 13 || v == 14) ? $sformatf("R1 vec%0d", v)
                                            : $sformatf("vec%0d", v);
            run_op(VMODE[v][2], VMODE[v][1:0], VA[v], VB[v], t);
        end

        // R7: a start pulse in mid-operation is ignored.
        @(negedge clk);
        start = 1'b1; is_signed = 1'b0; op_size = 2'b10;
        mcand = 32'hFFFFFFFF; mplier = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 100) begin
            if (k == 10) begin start = 1'b1; mcand = 32'h1; mplier = 32'h1; end
            else start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check("R7 busy start", "done cycle", 64'(k), 64'd38);
        check("R7 busy start", "product", {prod_hi, prod_lo}, 64'hFFFFFFFE00000001);
        dones = 0;
        repeat (60) begin @(negedge clk); if (done) dones++; end
        check("R7 busy start", "extra done pulses", 64'(dones), 64'h0);

        // R8: reset during an operation abandons it.
        @(negedge clk);
        start = 1'b1; is_signed = 1'b1; op_size = 2'b10;
        mcand = 32'h00000003; mplier = 32'h40000001;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R8 mid reset", "product", {prod_hi, prod_lo}, 64'h0);
        check("R8 mid reset", "cycle_count", {58'h0, cycle_count}, 64'h0);
        dones = 0;
        repeat (50) begin @(negedge clk); if (done) dones++; end
        check("R8 mid reset", "done pulses", 64'(dones), 64'h0);

        // Recovery after reset, signed negative multiplier with early exit (R3, R4).
        run_op(1'b1, 2'b01, 32'h00000077, 32'h0000FF80, "R3 post-reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule